// File: doc/BRIEF.md
# Address Translation Sequencer With Fault Codes

This block steers a single 32-bit effective-address translation from request to result. It holds sixteen segment registers, decides whether translation is enabled for the access, asks an external block-translation unit for a match, handles direct-store and no-execute segments, asks an external page-table walker for the page entry, and derives the page permissions from the segment key and the entry's two protection bits. The outcome is either a real address with read/write/execute permissions or a classified fault (instruction or data) with a fault code and, for data faults, a fault address.

One request is handled at a time. The requester raises `req_valid_i` for a cycle while `busy_o` is low; `done_o` pulses for one cycle when the outcome registers are updated. The block-translation and walk interfaces are level request / one-cycle response handshakes: the block holds its request high until the response strobe arrives.

Top module: `xlate_seq`

## Requirements
- R1: When the enable bit for the access is clear (`ir_en_i` for a fetch, `dr_en_i` for a load or store), the result is `ok_o`=1, `pa_o` equal to the effective address and `prot_o`=3'b111, with `done_o` one cycle after acceptance and no block or walk request. Access type: 0 load, 1 store, 2 fetch (3 is treated as a load). `prot_o` bit 0 is read, bit 1 write, bit 2 execute.
- R2: With translation on, the block-translation request comes first; on a hit its address and permissions are used, and if the permission bit needed by the access (read for load, write for store, execute for fetch) is missing, a protection fault is raised.
- R3: On a block-translation miss, the segment register selected by effective-address bits 31:28 is used; the walk request carries its bits 23:0 as `walk_vsid_o`. Segment layout: bit 31 direct-store, bit 30 supervisor key, bit 29 user key, bit 28 no-execute, bits 28:20 controller id, bits 3:0 address nibble.
- R4: The key is segment bit 29 when `user_i` is 1 and bit 30 otherwise.
- R5: Walk hit permissions: key 0 gives read/write for protection values 0..2 and read-only for 3; key 1 gives none for 0, read-only for 1 and 3, read/write for 2; execute is added when the segment no-execute bit is 0. The real address is `walk_rpn_i` followed by effective-address bits 11:0.
- R6: A fetch from a no-execute segment, or from a direct-store segment whose controller id is not 0x07F, gives an instruction fault with code 0x10000000 and no walk request.
- R7: A walk miss gives code 0x40000000 for fetches and loads and 0x42000000 for stores.
- R8: A protection violation gives code 0x08000000 for fetches and loads and 0x0A000000 for stores.
- R9: A direct-store segment with controller id 0x07F maps to segment bits 3:0 followed by effective-address bits 27:0, full permissions, for any access type.
- R10: In other direct-store segments a load succeeds only with key 0 and a store only with key 1, with `pa_o` equal to the effective address and `prot_o`=3'b011; otherwise a data protection fault (R8) is raised.
- R11: Every data fault sets `far_o` to the effective address; an instruction fault leaves `far_o` unchanged. Each `done_o` pulse carries exactly one of `ok_o`, `ifault_o`, `dfault_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_we_i | input | 1 | Segment register write strobe |
| seg_widx_i | input | 4 | Segment register write index |
| seg_wdata_i | input | 32 | Segment register write data |
| req_valid_i | input | 1 | Start a translation (accepted when not busy) |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| user_i | input | 1 | 1 for user mode, 0 for supervisor |
| ir_en_i | input | 1 | Instruction translation enable |
| dr_en_i | input | 1 | Data translation enable |
| blk_req_o | output | 1 | Block-translation request (held until response) |
| blk_ea_o | output | 32 | Address presented to block translation |
| blk_rsp_i | input | 1 | Block-translation response strobe |
| blk_hit_i | input | 1 | Block-translation match |
| blk_pa_i | input | 32 | Block-translated real address |
| blk_prot_i | input | 3 | Block permissions (read, write, execute) |
| walk_req_o | output | 1 | Page walk request (held until response) |
| walk_vsid_o | output | 24 | Segment id for the walk |
| walk_ea_o | output | 32 | Effective address for the walk |
| walk_rsp_i | input | 1 | Walk response strobe |
| walk_hit_i | input | 1 | Walk found an entry |
| walk_rpn_i | input | 20 | Real page number of the entry |
| walk_pp_i | input | 2 | Protection bits of the entry |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Translation succeeded |
| pa_o | output | 32 | Real address |
| prot_o | output | 3 | Permissions (read, write, execute) |
| ifault_o | output | 1 | Instruction fault |
| dfault_o | output | 1 | Data fault |
| fcode_o | output | 32 | Fault code / status |
| far_o | output | 32 | Fault address (data faults) |

## Verification
The hardest outcomes to reach are the ones that depend on the order of the chain: a segment that is both direct-store and no-execute, a block hit that must override a segment that would fault, and the key-dependent protection table where the same protection value grants different rights. The bench programs the segment registers through the write port and acts as both external responders, choosing hit or miss per request, then sweeps every protection value, key, access type and no-execute setting through the walk path and checks the permission or fault code against a table computed from the rules.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned PW = 12;

  // segment register field positions
  localparam int unsigned SEG_DS  = 31;
  localparam int unsigned SEG_KS  = 30;
  localparam int unsigned SEG_KU  = 29;
  localparam int unsigned SEG_NX  = 28;
  localparam logic [8:0]  CTRL_FORCED = 9'h07F;

  localparam logic [1:0] ACC_LD = 2'd0;
  localparam logic [1:0] ACC_ST = 2'd1;
  localparam logic [1:0] ACC_IF = 2'd2;

  localparam logic [31:0] CODE_SEG  = 32'h1000_0000;
  localparam logic [31:0] CODE_MISS = 32'h4000_0000;
  localparam logic [31:0] CODE_PROT = 32'h0800_0000;
  localparam logic [31:0] CODE_STB  = 32'h0200_0000;

  typedef enum logic [1:0] {ST_IDLE, ST_BLK, ST_WALK} seq_state_e;
  typedef enum logic [1:0] {FK_NONE, FK_SEG, FK_MISS, FK_PROT} fault_kind_e;

  function automatic logic [2:0] need_mask(input logic [1:0] acc);
    case (acc)
      ACC_ST:  need_mask = 3'b010;
      ACC_IF:  need_mask = 3'b100;
      default: need_mask = 3'b001;
    endcase
  endfunction
endpackage

// File: rtl/xlate_segfile.sv
module xlate_segfile #(
  parameter int unsigned NSEG = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned IW  = $clog2(NSEG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] seg_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   seg_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))             seg_q[g] <= wdata_i;
    end
  end

  assign rdata_o = seg_q[ridx_i];
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm (
  input  logic       key_i,
  input  logic [1:0] pp_i,
  input  logic       nx_i,
  output logic [2:0] prot_o
);
  logic [1:0] rw;
  always_comb begin
    if (!key_i) rw = (pp_i == 2'd3) ? 2'b01 : 2'b11;
    else case (pp_i)
      2'd0:    rw = 2'b00;
      2'd2:    rw = 2'b11;
      default: rw = 2'b01;
    endcase
  end
  assign prot_o = {~nx_i, rw};
endmodule

// File: rtl/xlate_fcode.sv
module xlate_fcode
  import xlate_pkg::*;
(
  input  fault_kind_e kind_i,
  input  logic [1:0]  acc_i,
  output logic [31:0] code_o
);
  logic st;
  assign st = (acc_i == ACC_ST);
  always_comb begin
    case (kind_i)
      FK_SEG:  code_o = CODE_SEG;
      FK_MISS: code_o = CODE_MISS | (st ? CODE_STB : 32'h0);
      FK_PROT: code_o = CODE_PROT | (st ? CODE_STB : 32'h0);
      default: code_o = 32'h0;
    endcase
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_pkg::*;
#(
  parameter int unsigned NSEG = 16,
  localparam int unsigned SIW = $clog2(NSEG),
  localparam int unsigned RPW = AW - PW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           seg_we_i,
  input  logic [SIW-1:0] seg_widx_i,
  input  logic [AW-1:0]  seg_wdata_i,
  input  logic           req_valid_i,
  input  logic [AW-1:0]  ea_i,
  input  logic [1:0]     acc_i,
  input  logic           user_i,
  input  logic           ir_en_i,
  input  logic           dr_en_i,
  output logic           blk_req_o,
  output logic [AW-1:0]  blk_ea_o,
  input  logic           blk_rsp_i,
  input  logic           blk_hit_i,
  input  logic [AW-1:0]  blk_pa_i,
  input  logic [2:0]     blk_prot_i,
  output logic           walk_req_o,
  output logic [23:0]    walk_vsid_o,
  output logic [AW-1:0]  walk_ea_o,
  input  logic           walk_rsp_i,
  input  logic           walk_hit_i,
  input  logic [RPW-1:0] walk_rpn_i,
  input  logic [1:0]     walk_pp_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           ok_o,
  output logic [AW-1:0]  pa_o,
  output logic [2:0]     prot_o,
  output logic           ifault_o,
  output logic           dfault_o,
  output logic [31:0]    fcode_o,
  output logic [AW-1:0]  far_o
);
  seq_state_e   state_q, state_d;
  logic [AW-1:0] ea_q, seg_q, seg_rd;
  logic [1:0]    acc_q;
  logic          user_q;

  xlate_segfile #(.NSEG(NSEG), .DW(AW)) u_segs (
    .clk_i, .rst_ni,
    .we_i(seg_we_i), .widx_i(seg_widx_i), .wdata_i(seg_wdata_i),
    .ridx_i(ea_i[AW-1 -: SIW]), .rdata_o(seg_rd)
  );

  logic fetch_q, store_q, key, forced;
  assign fetch_q = (acc_q == ACC_IF);
  assign store_q = (acc_q == ACC_ST);
  assign key     = user_q ? seg_q[SEG_KU] : seg_q[SEG_KS];
  assign forced  = (seg_q[28:20] == CTRL_FORCED);

  logic [2:0] walk_prot;
  xlate_perm u_perm (.key_i(key), .pp_i(walk_pp_i), .nx_i(seg_q[SEG_NX]), .prot_o(walk_prot));

  // outcome of the current cycle
  logic          fin, f_ok;
  fault_kind_e   f_kind;
  logic [AW-1:0] f_pa;
  logic [2:0]    f_prot;
  logic          real_mode;
  logic [2:0]    need;

  assign real_mode = (acc_i == ACC_IF) ? !ir_en_i : !dr_en_i;
  assign need      = need_mask(acc_q);

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    f_ok    = 1'b0;
    f_kind  = FK_NONE;
    f_pa    = ea_q;
    f_prot  = 3'b000;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (real_mode) begin
          fin = 1'b1; f_ok = 1'b1; f_pa = ea_i; f_prot = 3'b111;
        end else begin
          state_d = ST_BLK;
        end
      end
      ST_BLK: if (blk_rsp_i) begin
        state_d = ST_IDLE;
        fin     = 1'b1;
        if (blk_hit_i) begin
          if ((need & ~blk_prot_i) != 3'b000) f_kind = FK_PROT;
          else begin f_ok = 1'b1; f_pa = blk_pa_i; f_prot = blk_prot_i; end
        end else if (seg_q[SEG_DS]) begin
          if (forced) begin
            f_ok = 1'b1; f_pa = {seg_q[3:0], ea_q[27:0]}; f_prot = 3'b111;
          end else if (fetch_q) f_kind = FK_SEG;
          else if (store_q == key) begin f_ok = 1'b1; f_prot = 3'b011; end
          else f_kind = FK_PROT;
        end else if (fetch_q && seg_q[SEG_NX]) begin
          f_kind = FK_SEG;
        end else begin
          fin = 1'b0; state_d = ST_WALK;
        end
      end
      ST_WALK: if (walk_rsp_i) begin
        state_d = ST_IDLE;
        fin     = 1'b1;
        if (!walk_hit_i) f_kind = FK_MISS;
        else if ((need & ~walk_prot) != 3'b000) f_kind = FK_PROT;
        else begin f_ok = 1'b1; f_pa = {walk_rpn_i, ea_q[PW-1:0]}; f_prot = walk_prot; end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  logic [31:0] f_code;
  logic [1:0]  fin_acc;
  assign fin_acc = (state_q == ST_IDLE) ? acc_i : acc_q;
  xlate_fcode u_fcode (.kind_i(f_kind), .acc_i(fin_acc), .code_o(f_code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ea_q     <= '0;
      seg_q    <= '0;
      acc_q    <= ACC_LD;
      user_q   <= 1'b0;
      done_o   <= 1'b0;
      ok_o     <= 1'b0;
      pa_o     <= '0;
      prot_o   <= '0;
      ifault_o <= 1'b0;
      dfault_o <= 1'b0;
      fcode_o  <= '0;
      far_o    <= '0;
    end else begin
      state_q <= state_d;
      done_o  <= fin;
      if (state_q == ST_IDLE && req_valid_i) begin
        ea_q   <= ea_i;
        seg_q  <= seg_rd;
        acc_q  <= acc_i;
        user_q <= user_i;
      end
      if (fin) begin
        ok_o     <= f_ok;
        pa_o     <= f_pa;
        prot_o   <= f_prot;
        ifault_o <= !f_ok && fetch_q;
        dfault_o <= !f_ok && !fetch_q;
        fcode_o  <= f_ok ? 32'h0 : f_code;
        if (!f_ok && !fetch_q) far_o <= ea_q;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign blk_req_o   = (state_q == ST_BLK);
  assign blk_ea_o    = ea_q;
  assign walk_req_o  = (state_q == ST_WALK);
  assign walk_vsid_o = seg_q[23:0];
  assign walk_ea_o   = ea_q;

  // R2: only one external request at a time
  a_r2_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({blk_req_o, walk_req_o}));
  // R2: a walk starts only after the block-translation request
  a_r2_walk_after_blk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(walk_req_o) |-> $past(blk_req_o));
  // R6: no walk for a fetch from a no-execute segment
  a_r6_nx_no_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o |-> !(fetch_q && seg_q[SEG_NX]));
  // R11: exactly one outcome per completion
  a_r11_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({ok_o, ifault_o, dfault_o}) == 1);
  // R11: data faults report the captured address
  a_r11_far: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dfault_o) |-> far_o == ea_q);
  // R1: real-mode completion touches no external unit
  a_r1_real_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_valid_i && real_mode) |=> (done_o && !blk_req_o));
endmodule

// File: tb/xlate_seq_tb_top.sv
module xlate_seq_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n;
  logic        seg_we;
  logic [3:0]  seg_widx;
  logic [31:0] seg_wdata;
  logic        req_valid;
  logic [31:0] ea;
  logic [1:0]  acc;
  logic        user, ir_en, dr_en;
  logic        blk_req, blk_rsp, blk_hit;
  logic [31:0] blk_ea, blk_pa;
  logic [2:0]  blk_prot;
  logic        walk_req, walk_rsp, walk_hit;
  logic [23:0] walk_vsid;
  logic [31:0] walk_ea;
  logic [19:0] walk_rpn;
  logic [1:0]  walk_pp;
  logic        busy, done, ok, ifault, dfault;
  logic [31:0] pa, fcode, far;
  logic [2:0]  prot;

  xlate_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_we_i(seg_we), .seg_widx_i(seg_widx), .seg_wdata_i(seg_wdata),
    .req_valid_i(req_valid), .ea_i(ea), .acc_i(acc), .user_i(user),
    .ir_en_i(ir_en), .dr_en_i(dr_en),
    .blk_req_o(blk_req), .blk_ea_o(blk_ea), .blk_rsp_i(blk_rsp),
    .blk_hit_i(blk_hit), .blk_pa_i(blk_pa), .blk_prot_i(blk_prot),
    .walk_req_o(walk_req), .walk_vsid_o(walk_vsid), .walk_ea_o(walk_ea),
    .walk_rsp_i(walk_rsp), .walk_hit_i(walk_hit), .walk_rpn_i(walk_rpn),
    .walk_pp_i(walk_pp),
    .busy_o(busy), .done_o(done), .ok_o(ok), .pa_o(pa), .prot_o(prot),
    .ifault_o(ifault), .dfault_o(dfault), .fcode_o(fcode), .far_o(far)
  );

  int n_chk = 0, n_fail = 0;
  logic saw_blk, saw_walk, timed_out;
  logic [23:0] seen_vsid;
  int lat;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic wr_seg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    seg_we = 1'b1; seg_widx = idx; seg_wdata = val;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  // one translation; responders answer with the given values
  task automatic xl(input logic [31:0] a, input logic [1:0] t, input logic u,
                    input logic bh, input logic [31:0] bpa, input logic [2:0] bpr,
                    input logic wh, input logic [19:0] rpn, input logic [1:0] pp);
    @(negedge clk);
    ea = a; acc = t; user = u; req_valid = 1'b1;
    blk_hit = bh; blk_pa = bpa; blk_prot = bpr;
    walk_hit = wh; walk_rpn = rpn; walk_pp = pp;
    saw_blk = 1'b0; saw_walk = 1'b0; timed_out = 1'b0; lat = 1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (done) break;
      if (blk_req) saw_blk = 1'b1;
      if (walk_req) begin saw_walk = 1'b1; seen_vsid = walk_vsid; end
      blk_rsp  = blk_req;
      walk_rsp = walk_req;
      @(negedge clk);
      lat++;
    end
    blk_rsp = 1'b0; walk_rsp = 1'b0;
    if (!done) begin
      timed_out = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL handshake: actual no done expected done");
    end
  endtask

  function automatic logic [2:0] exp_prot(input logic k, input logic [1:0] p, input logic nx);
    logic [1:0] rw;
    if (!k) rw = (p == 3) ? 2'b01 : 2'b11;
    else rw = (p == 0) ? 2'b00 : (p == 2) ? 2'b11 : 2'b01;
    return {~nx, rw};
  endfunction

  function automatic logic [2:0] need_of(input logic [1:0] t);
    return (t == 1) ? 3'b010 : (t == 2) ? 3'b100 : 3'b001;
  endfunction

  initial begin
    rst_n = 1'b0; seg_we = 0; seg_widx = 0; seg_wdata = 0; req_valid = 0;
    ea = 0; acc = 0; user = 0; ir_en = 1; dr_en = 1;
    blk_rsp = 0; blk_hit = 0; blk_pa = 0; blk_prot = 0;
    walk_rsp = 0; walk_hit = 0; walk_rpn = 0; walk_pp = 0;
    repeat (3) @(negedge clk);
    // reset state (R11)
    chk("R11 reset busy", {31'b0, busy}, 0);
    chk("R11 reset done", {31'b0, done}, 0);
    chk("R11 reset outcome", {29'b0, ok, ifault, dfault}, 0);
    chk("R2 reset requests", {30'b0, blk_req, walk_req}, 0);
    rst_n = 1'b1;

    // R1: real mode for data and for fetch
    dr_en = 0; ir_en = 1;
    xl(32'h1234_5678, 0, 0, 1, 32'hDEAD_0000, 3'b000, 1, 0, 0);
    chk("R1 real ok", {31'b0, ok}, 1);
    chk("R1 real pa", pa, 32'h1234_5678);
    chk("R1 real prot", {29'b0, prot}, 3'b111);
    chk("R1 real latency", lat, 1);
    chk("R1 no blk req", {31'b0, saw_blk}, 0);
    dr_en = 1; ir_en = 0;
    xl(32'h8765_4321, 2, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 fetch real pa", pa, 32'h8765_4321);
    chk("R1 fetch real ok", {31'b0, ok}, 1);
    dr_en = 0; ir_en = 1;
    xl(32'h0000_1000, 2, 0, 1, 32'h5555_1000, 3'b101, 0, 0, 0);
    chk("R1 fetch uses ir_en", pa, 32'h5555_1000);
    dr_en = 1;

    // R2: block hit and block protection fault
    wr_seg(4'h3, 32'h9000_0000);  // direct-store, would fault a fetch
    xl(32'h3000_0ABC, 2, 0, 1, 32'h7000_0ABC, 3'b101, 0, 0, 0);
    chk("R2 blk hit overrides segment", pa, 32'h7000_0ABC);
    chk("R2 blk prot", {29'b0, prot}, 3'b101);
    chk("R2 blk no walk", {31'b0, saw_walk}, 0);
    xl(32'h3000_0FF0, 1, 0, 1, 32'h7000_0FF0, 3'b101, 0, 0, 0);
    chk("R2 blk store fault", {31'b0, dfault}, 1);
    chk("R8 blk store code", fcode, 32'h0A00_0000);
    chk("R11 far on dfault", far, 32'h3000_0FF0);

    // R3: segment selection by ea[31:28]
    wr_seg(4'h5, 32'h00AB_CDEF);
    wr_seg(4'h6, 32'h0012_3456);
    xl(32'h5000_2000, 0, 0, 0, 0, 0, 1, 20'h11111, 0);
    chk("R3 vsid seg5", {8'b0, seen_vsid}, 32'h00AB_CDEF);
    chk("R5 walk pa", pa, 32'h1111_1000);
    xl(32'h6FFF_F123, 0, 0, 0, 0, 0, 1, 20'h22222, 0);
    chk("R3 vsid seg6", {8'b0, seen_vsid}, 32'h0012_3456);
    chk("R5 walk pa offset", pa, 32'h2222_2123);

    // R9: forced direct-store mapping
    wr_seg(4'h0, 32'h8000_0000 | (32'h07F << 20) | 32'hA);
    for (int t = 0; t < 3; t++) begin
      xl(32'h0123_4567, 2'(t), 1, 0, 0, 0, 0, 0, 0);
      chk("R9 forced pa", pa, 32'hA123_4567);
      chk("R9 forced prot", {29'b0, prot}, 3'b111);
    end

    // R6: direct-store fetch and no-execute fetch; R11: far kept on ifault
    wr_seg(4'h1, 32'h8000_0000);
    xl(32'h1000_0040, 2, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 ds fetch ifault", {31'b0, ifault}, 1);
    chk("R6 ds fetch code", fcode, 32'h1000_0000);
    chk("R11 far kept on ifault", far, 32'h3000_0FF0);
    wr_seg(4'h2, 32'h1000_0042);
    xl(32'h2000_0080, 2, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 nx fetch code", fcode, 32'h1000_0000);
    chk("R6 nx no walk", {31'b0, saw_walk}, 0);
    xl(32'h2000_0084, 0, 0, 0, 0, 0, 1, 20'h00ABC, 0);
    chk("R6 nx load walks", pa, 32'h00AB_C084);

    // R10: other direct-store data; R4: key choice
    wr_seg(4'h1, 32'h8000_0000 | (32'h1 << SEG_KU_BIT()));  // user key 1, sup key 0
    xl(32'h1000_0100, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 ds load key0 ok", {31'b0, ok}, 1);
    chk("R10 ds load pa", pa, 32'h1000_0100);
    chk("R10 ds prot", {29'b0, prot}, 3'b011);
    xl(32'h1000_0104, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 ds store key0 fault", fcode, 32'h0A00_0000);
    xl(32'h1000_0108, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R4 user key1 store ok", {31'b0, ok}, 1);
    xl(32'h1000_010C, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R10 ds load key1 fault", fcode, 32'h0800_0000);
    chk("R11 far ds", far, 32'h1000_010C);

    // R7: walk miss codes
    for (int t = 0; t < 3; t++) begin
      xl(32'h5000_3000 + t, 2'(t), 0, 0, 0, 0, 0, 0, 0);
      chk("R7 miss code", fcode, (t == 1) ? 32'h4200_0000 : 32'h4000_0000);
      chk("R7 miss class", {30'b0, ifault, dfault}, (t == 2) ? 2'b10 : 2'b01);
    end

    // R4, R5, R8: sweep key source, protection bits, access, no-execute
    for (int nx = 0; nx < 2; nx++)
      for (int ks = 0; ks < 2; ks++)
        for (int ku = 0; ku < 2; ku++) begin
          wr_seg(4'h7, (32'(ks) << 30) | (32'(ku) << 29) | (32'(nx) << 28) | 32'h0000_0777);
          for (int u = 0; u < 2; u++)
            for (int p = 0; p < 4; p++)
              for (int t = 0; t < 3; t++) begin
                logic k;
                logic [2:0] ep;
                logic [31:0] a;
                k  = u ? ku[0] : ks[0];
                ep = exp_prot(k, 2'(p), nx[0]);
                a  = 32'h7000_0000 | (32'(p) << 12) | 32'(t * 4 + u);
                xl(a, 2'(t), u[0], 0, 0, 0, 1, 20'h3C000 + 20'(p), 2'(p));
                if (t == 2 && nx == 1) begin
                  chk("R6 sweep nx fetch", fcode, 32'h1000_0000);
                end else if ((need_of(2'(t)) & ~ep) != 0) begin
                  chk("R8 sweep code", fcode, (t == 1) ? 32'h0A00_0000 : 32'h0800_0000);
                  if (t != 2) chk("R11 sweep far", far, a);
                end else begin
                  chk("R5 sweep prot", {29'b0, prot}, {29'b0, ep});
                  chk("R5 sweep pa", pa, {20'h3C000 + 20'(p), a[11:0]});
                end
              end
        end

    finish_run();
  end

  function automatic int SEG_KU_BIT();
    return 29;
  endfunction
endmodule